// File: doc/BRIEF.md
# Shifter with Carry and Extend Output

This block is a purely combinational barrel shifter for a 32-bit datapath. It shifts an operand left, logically right or arithmetically right. Along with the shifted value it produces a carry-out bit and an extend bit, which are the flag bits that a shift instruction leaves behind for the next instruction. The N and Z flags are not produced here; a separate flag evaluator derives them from the result.

The count is treated as a 6-bit quantity, so the count runs from 0 to 63. Counts of zero, exactly the word width and beyond the word width each have their own defined result and carry. A zero count leaves the operand alone and carries the previous carry flag through, so a shift by a register holding zero does not change the carry flag. Rotates and instruction decode are outside this unit.

Top module: `shift_cx_unit`

## Requirements
- R1: The count input is 8 bits wide and only its low 6 bits take effect, so a count of n+64·k behaves exactly as n for every k.
- R2: For a 6-bit count of 0 and a non-reserved kind, the result equals the operand and the carry equals the previous carry input.
- R3: A left shift (kind 2'b00) by n from 1 to 31 gives the operand shifted left with zeros filled in, and the carry is operand bit 32-n.
- R4: A right shift by n from 1 to 31 fills with zeros for the logical kind (2'b01) and with copies of bit 31 for the arithmetic kind (2'b10); the carry is operand bit n-1.
- R5: A logical shift by exactly 32 gives a zero result; the carry is operand bit 0 for a left shift and operand bit 31 for a right shift.
- R6: A logical shift (left or right) by 33 to 63 gives a zero result and a zero carry.
- R7: An arithmetic right shift by 32 to 63 gives a result with every bit equal to operand bit 31, and the carry equals operand bit 31.
- R8: The extend output equals the carry output for every input combination.
- R9: Kind 2'b11 is reserved: for any count and previous carry, the result equals the operand and the carry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to be shifted |
| count_i | input | 8 | Shift count; only the low 6 bits are used |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 reserved |
| carry_prev_i | input | 1 | Carry flag before the shift, returned for a zero count |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Last bit shifted out, or the special-count carry |
| extend_o | output | 1 | Extend flag, a copy of the carry |

## Verification
The bench sweeps every 6-bit count with all four kinds, both previous-carry values and operands chosen so that the bits next to each boundary differ. It aims at the count boundaries: a design that masks the count to 5 bits makes a shift by 32 behave like a shift by 0, and a design that computes the carry with an off-by-one index shows up on counts 1 and 31. It also covers a zero count that clears the carry instead of keeping it, an arithmetic shift past 32 that fills with zeros, a logical shift past 32 that still reports a carry, and a reserved kind that shifts anyway. It repeats counts with the upper count bits set, which catches a design that decodes those bits as part of the count.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [1:0] {
    SH_LEFT   = 2'b00,
    SH_LRIGHT = 2'b01,
    SH_ARIGHT = 2'b10,
    SH_RSVD   = 2'b11
  } shift_kind_e;

  // Exactly one class is true for any effective count.
  typedef struct packed {
    logic zero;
    logic in_range;
    logic exact;
    logic over;
  } count_class_t;

  // Fill bit for a right shift: sign for arithmetic, zero otherwise.
  function automatic logic fill_bit(input shift_kind_e kind, input logic msb);
    return (kind == SH_ARIGHT) ? msb : 1'b0;
  endfunction

endpackage

// File: rtl/shift_count_class.sv
module shift_count_class
  import shifter_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8,
  localparam int CNT_W   = $clog2(DATA_W) + 1
) (
  input  logic [CNT_IN_W-1:0] count_raw_i,
  output logic [CNT_W-1:0]    amount_o,
  output count_class_t        cls_o
);

  localparam logic [CNT_W-1:0] WIDTH_CNT = CNT_W'(DATA_W);
  localparam int               MODULUS   = 2 ** CNT_W;

  logic [CNT_IN_W-1:0] wrapped;

  always_comb begin
    wrapped         = count_raw_i % CNT_IN_W'(MODULUS);
    amount_o        = wrapped[CNT_W-1:0];
    cls_o.zero      = (amount_o == '0);
    cls_o.exact     = (amount_o == WIDTH_CNT);
    cls_o.over      = (amount_o > WIDTH_CNT);
    cls_o.in_range  = (amount_o != '0) && (amount_o < WIDTH_CNT);
  end

  // R1: the classification must cover every effective count exactly once.
  always_comb begin
    assert_class_onehot_R1: assert ($onehot({cls_o.zero, cls_o.in_range,
                                             cls_o.exact, cls_o.over}))
      else $error("count class not one-hot for count %0d", amount_o);
  end

endmodule

// File: rtl/shift_barrel.sv
module shift_barrel
  import shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int STG   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [STG-1:0]    amt_i,
  input  shift_kind_e       kind_i,
  output logic [DATA_W-1:0] result_o
);

  logic [DATA_W-1:0] lft [0:STG];
  logic [DATA_W-1:0] rgt [0:STG];
  logic              fill;

  assign fill   = fill_bit(kind_i, operand_i[DATA_W-1]);
  assign lft[0] = operand_i;
  assign rgt[0] = operand_i;

  for (genvar k = 0; k < STG; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign lft[k+1] = amt_i[k] ? {lft[k][DATA_W-1-SH:0], {SH{1'b0}}} : lft[k];
    assign rgt[k+1] = amt_i[k] ? {{SH{fill}}, rgt[k][DATA_W-1:SH]}   : rgt[k];
  end

  assign result_o = (kind_i == SH_LEFT) ? lft[STG] : rgt[STG];

  logic [DATA_W-1:0] low_mask;
  assign low_mask = ~({DATA_W{1'b1}} << amt_i);

  // R3: vacated low bits of a left shift are zero.
  // R4: an arithmetic right shift keeps the sign in the top bit.
  always_comb begin
    if (kind_i == SH_LEFT)
      assert_left_zero_fill_R3: assert ((result_o & low_mask) == '0)
        else $error("left shift left nonzero low bits");
    if (kind_i == SH_ARIGHT)
      assert_arith_sign_keep_R4: assert (result_o[DATA_W-1] == operand_i[DATA_W-1])
        else $error("arithmetic shift lost the sign bit");
  end

endmodule

// File: rtl/shift_carry_pick.sv
module shift_carry_pick
  import shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W) + 1,
  localparam int STG   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CNT_W-1:0]  amount_i,
  input  count_class_t      cls_i,
  input  shift_kind_e       kind_i,
  input  logic              carry_prev_i,
  output logic              carry_o
);

  localparam logic [CNT_W-1:0] WIDTH_CNT = CNT_W'(DATA_W);

  logic [CNT_W-1:0] diff_left;
  logic [CNT_W-1:0] diff_right;
  logic [STG-1:0]   idx_left;
  logic [STG-1:0]   idx_right;

  always_comb begin
    diff_left  = WIDTH_CNT - amount_i;
    diff_right = amount_i - CNT_W'(1);
    idx_left   = diff_left[STG-1:0];
    idx_right  = diff_right[STG-1:0];
  end

  always_comb begin
    carry_o = 1'b0;
    if (kind_i == SH_RSVD) begin
      carry_o = 1'b0;
    end else if (cls_i.zero) begin
      carry_o = carry_prev_i;
    end else if (cls_i.in_range) begin
      carry_o = (kind_i == SH_LEFT) ? operand_i[idx_left] : operand_i[idx_right];
    end else if (cls_i.exact) begin
      carry_o = (kind_i == SH_LEFT) ? operand_i[0] : operand_i[DATA_W-1];
    end else begin
      carry_o = (kind_i == SH_ARIGHT) ? operand_i[DATA_W-1] : 1'b0;
    end
  end

endmodule

// File: rtl/shift_cx_unit.sv
module shift_cx_unit
  import shifter_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8
) (
  input  logic [DATA_W-1:0]   operand_i,
  input  logic [CNT_IN_W-1:0] count_i,
  input  logic [1:0]          kind_i,
  input  logic                carry_prev_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                carry_o,
  output logic                extend_o
);

  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam int STG   = $clog2(DATA_W);

  shift_kind_e       kind;
  logic [CNT_W-1:0]  amount;
  count_class_t      cls;
  logic [DATA_W-1:0] barrel_res;
  logic              carry_sel;
  logic              sign;

  assign kind = shift_kind_e'(kind_i);
  assign sign = operand_i[DATA_W-1];

  shift_count_class #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) class_i (
    .count_raw_i (count_i),
    .amount_o    (amount),
    .cls_o       (cls)
  );

  shift_barrel #(.DATA_W(DATA_W)) barrel_i (
    .operand_i (operand_i),
    .amt_i     (amount[STG-1:0]),
    .kind_i    (kind),
    .result_o  (barrel_res)
  );

  shift_carry_pick #(.DATA_W(DATA_W)) carry_i (
    .operand_i    (operand_i),
    .amount_i     (amount),
    .cls_i        (cls),
    .kind_i       (kind),
    .carry_prev_i (carry_prev_i),
    .carry_o      (carry_sel)
  );

  always_comb begin
    if (kind == SH_RSVD || cls.zero)
      result_o = operand_i;
    else if (cls.in_range)
      result_o = barrel_res;
    else if (kind == SH_ARIGHT)
      result_o = {DATA_W{sign}};
    else
      result_o = '0;
  end

  assign carry_o  = carry_sel;
  assign extend_o = carry_sel;

  // Output-level checks across the count classifier, barrel and carry picker.
  always_comb begin
    if (kind != SH_RSVD && count_i[CNT_W-1:0] == '0)
      assert_zero_count_keep_R2: assert (result_o == operand_i && carry_o == carry_prev_i)
        else $error("zero count changed operand or carry");
    if (kind != SH_ARIGHT && kind != SH_RSVD && cls.over)
      assert_logical_over_clear_R6: assert (result_o == '0 && carry_o == 1'b0)
        else $error("logical shift past width not cleared");
    if (kind == SH_ARIGHT && (cls.exact || cls.over))
      assert_arith_saturate_R7: assert ((result_o == '0 || result_o == '1) &&
                                        result_o[0] == sign && carry_o == sign)
        else $error("arithmetic shift past width not sign filled");
    if (kind == SH_RSVD)
      assert_reserved_passthru_R9: assert (result_o == operand_i && !carry_o && !extend_o)
        else $error("reserved kind altered operand or carry");
  end

endmodule

// File: tb/shift_cx_unit_tb_top.sv
module shift_cx_unit_tb_top;

  logic        clk = 1'b0;
  logic [31:0] operand;
  logic [7:0]  count;
  logic [1:0]  kind;
  logic        prev;
  logic [31:0] result;
  logic        carry;
  logic        extend;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  shift_cx_unit dut_i (
    .operand_i    (operand),
    .count_i      (count),
    .kind_i       (kind),
    .carry_prev_i (prev),
    .result_o     (result),
    .carry_o      (carry),
    .extend_o     (extend)
  );

  // Reference: the operand sits inside a wide word so that every shifted-out
  // bit, including those past the word edge, lands at a fixed position.
  task automatic model(input logic [31:0] op, input int n, input int k, input logic pc,
                       output logic [31:0] r, output logic c);
    logic [127:0] t;
    if (k == 3) begin
      r = op; c = 1'b0;
    end else if (n == 0) begin
      r = op; c = pc;
    end else if (k == 0) begin
      t = {96'b0, op} << n;
      r = t[31:0]; c = t[32];
    end else if (k == 1) begin
      t = {64'b0, op, 32'b0} >> n;
      r = t[63:32]; c = t[31];
    end else begin
      t = {{64{op[31]}}, op, 32'b0} >> n;
      r = t[63:32]; c = t[31];
    end
  endtask

  function automatic string tag_for(input int n, input int k);
    if (k == 3) return "R9";
    if (n == 0) return "R2";
    if (n < 32) return (k == 0) ? "R3" : "R4";
    if (k == 2) return "R7";
    if (n == 32) return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [31:0] got_r, input logic got_c,
                       input logic [31:0] exp_r, input logic exp_c);
    checks++;
    if (got_r !== exp_r || got_c !== exp_c) begin
      fails++;
      $display("FAIL %s: op=%h cnt=%0d kind=%0d prev=%0b got result=%h carry=%0b expected result=%h carry=%0b",
               tag, operand, count, kind, prev, got_r, got_c, exp_r, exp_c);
    end
  endtask

  task automatic apply_and_check(input logic [31:0] op, input int raw, input int k,
                                 input logic pc, input string forced_tag);
    logic [31:0] er;
    logic        ec;
    @(posedge clk);
    #1;
    operand = op; count = 8'(raw); kind = 2'(k); prev = pc;
    #3;
    model(op, raw % 64, k, pc, er, ec);
    check((forced_tag != "") ? forced_tag : tag_for(raw % 64, k), result, carry, er, ec);
    check("R8", 32'(extend), extend, 32'(carry), carry);
  endtask

  logic [31:0] ops [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001,
                           32'h1234_5678, 32'h89AB_CDEF, 32'h7FFF_FFFE, 32'hA5A5_A5A5};

  initial begin
    operand = '0; count = '0; kind = '0; prev = 1'b0;
    #5;
    // R2: all-zero inputs at start give a zero result and zero carry
    check("R2", result, carry, 32'h0, 1'b0);
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 64; n++)
        for (int o = 0; o < 8; o++)
          for (int p = 0; p < 2; p++)
            apply_and_check(ops[o], n, k, p[0], "");
    // R1: upper count bits set must not change behaviour
    for (int hi = 1; hi < 4; hi++)
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < 64; n += 7)
          for (int o = 2; o < 6; o++)
            apply_and_check(ops[o], n + 64 * hi, k, n[0], "R1");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule